// File: doc/BRIEF.md
# Debug Address Translation Request Port

This block is a small register front end that lets software ask an address-translation unit to translate one I/O virtual address, then read back the outcome. Software loads a 64-bit address register, then writes a 64-bit control register that holds the process ID, the device ID and the permissions wanted. Setting the Go/Busy bit in that write starts the request. The block sends the request to the translation engine over a valid/ready handshake and waits for one response. It then updates a read-only response register and clears Go/Busy.

Every request the block issues tells the engine to leave its translation cache unchanged. The engine may still hit on entries that are already cached. Each request is also tagged as an untranslated request, so the engine's performance counters count it as one. When the translation faults, a one-cycle fault record goes out on a separate output for the fault-reporting logic. The whole port is controlled by a capability flag. When the flag is low, the port is hidden.

Top module: `dbg_xlate_regs`

## Requirements
- R1: While `dbg_cap_i` is 0, every register reads as zero. Writes change no state and launch no request.
- R2: Register index 0 holds the address and all 64 bits are writable. Index 1 holds the control register:
  - bit 0 is Go/Busy
  - bits 3:1 are the execute, write and read permission requests (bit 3 execute, bit 1 read)
  - bits 31:12 are the process ID
  - bits 63:40 are the device ID
  - all other bits read as zero

  Index 2 holds the response and is read-only. Index 3 reads as zero.
- R3: A control write with bit 0 set while idle does three things: it sets Go/Busy, it clears the response register to zero, and it raises `eng_req_valid_o` in the next cycle. The request carries the register contents.
- R4: A software write cannot clear Go/Busy. Only completion of the request clears it.
- R5: `eng_req_valid_o` stays high with unchanged request fields until a cycle in which `eng_req_ready_i` is high, and then drops. Only one request is outstanding at a time.
- R6: When a response arrives without a fault, Go/Busy clears at that clock edge. The response register then holds the physical page number in bits 63:10, the attribute bits in 9:7, and zero in bits 6:0.
- R7: When a response reports a fault, two things happen at that edge:
  - the response register becomes 1 (fault flag only)
  - `flt_valid_o` pulses high for exactly the first cycle in which Go/Busy is clear, carrying the engine's cause code, the request address and the device ID
- R8: A response that flags an MSI entry in remapped-interrupt-file mode is reported as a fault with cause 260, whatever the engine's fault flag and cause inputs are.
- R9: While Go/Busy is 1, writes to the address and control registers are dropped.
- R10: `eng_req_no_alloc_o` and `eng_req_untrans_o` are 1 whenever `eng_req_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_cap_i | input | 1 | Debug translation capability enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index for read and write |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data (combinational) |
| eng_req_valid_o | output | 1 | Request valid toward the engine |
| eng_req_ready_i | input | 1 | Engine accepts the request |
| eng_req_iova_o | output | 64 | Address to translate |
| eng_req_pid_o | output | 20 | Process ID |
| eng_req_did_o | output | 24 | Device ID |
| eng_req_perm_o | output | 3 | Permissions {execute, write, read} |
| eng_req_no_alloc_o | output | 1 | Do not fill the translation cache |
| eng_req_untrans_o | output | 1 | Request counts as untranslated |
| eng_rsp_valid_i | input | 1 | Engine response valid |
| eng_rsp_fault_i | input | 1 | Translation faulted |
| eng_rsp_mrif_i | input | 1 | Hit an MSI entry in remapped-interrupt-file mode |
| eng_rsp_cause_i | input | 12 | Engine fault cause |
| eng_rsp_ppn_i | input | 54 | Translated physical page number |
| eng_rsp_attr_i | input | 3 | Page size and attribute bits |
| flt_valid_o | output | 1 | Fault record valid, one cycle |
| flt_cause_o | output | 12 | Fault cause |
| flt_iova_o | output | 64 | Faulting address |
| flt_did_o | output | 24 | Faulting device ID |

## Verification
The assertions assume that the engine behaves well:
- it raises `eng_rsp_valid_i` only after it has accepted a request
- it never raises `eng_rsp_valid_i` in the same cycle as `eng_req_ready_i`
- `dbg_cap_i` does not change while a request is outstanding

The bench's engine tasks respect these rules. They wait for valid before driving ready, then hold a programmed number of idle cycles before a one-cycle response pulse. The capability flag changes only while the port is idle. Software writes during a busy request are made on purpose, to show that they are dropped.

// File: rtl/dbg_xlate_pkg.sv
package dbg_xlate_pkg;
  localparam int DATA_W  = 64;
  localparam int PID_W   = 20;
  localparam int DID_W   = 24;
  localparam int PERM_W  = 3;
  localparam int CAUSE_W = 12;
  localparam int ATTR_W  = 3;
  localparam int PPN_W   = DATA_W - ATTR_W - 7;
  localparam int IDX_W   = 2;

  localparam logic [IDX_W-1:0]   IDX_IOVA = 2'd0;
  localparam logic [IDX_W-1:0]   IDX_CTL  = 2'd1;
  localparam logic [IDX_W-1:0]   IDX_RSP  = 2'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_TTYPE_BLOCKED = 12'd260;

  typedef struct packed {
    logic [DID_W-1:0]  did;
    logic [7:0]        rsvd_hi;
    logic [PID_W-1:0]  pid;
    logic [7:0]        rsvd_lo;
    logic [PERM_W-1:0] perm;
    logic              go;
  } ctl_reg_t;

  typedef struct packed {
    logic [PPN_W-1:0]  ppn;
    logic [ATTR_W-1:0] attr;
    logic [5:0]        rsvd;
    logic              fault;
  } rsp_reg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} xl_state_e;
endpackage

// File: rtl/dbg_xlate_csr.sv
module dbg_xlate_csr
  import dbg_xlate_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_i,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                busy_i,
  input  logic [DATA_W-1:0]   rsp_i,
  output logic                launch_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [DATA_W-1:0]   iova_o,
  output logic [PID_W-1:0]    pid_o,
  output logic [DID_W-1:0]    did_o,
  output logic [PERM_W-1:0]   perm_o
);
  logic [DATA_W-1:0] iova_q;
  logic [PID_W-1:0]  pid_q;
  logic [DID_W-1:0]  did_q;
  logic [PERM_W-1:0] perm_q;
  ctl_reg_t          wr_ctl, rd_ctl;
  logic              wr_ok;

  assign wr_ctl   = ctl_reg_t'(wdata_i);
  // software writes are dropped while a request is outstanding
  assign wr_ok    = cap_i && we_i && !busy_i;
  assign launch_o = wr_ok && (addr_i == IDX_CTL) && wr_ctl.go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iova_q <= '0;
      pid_q  <= '0;
      did_q  <= '0;
      perm_q <= '0;
    end else if (wr_ok) begin
      if (addr_i == IDX_IOVA) iova_q <= wdata_i;
      if (addr_i == IDX_CTL) begin
        pid_q  <= wr_ctl.pid;
        did_q  <= wr_ctl.did;
        perm_q <= wr_ctl.perm;
      end
    end
  end

  always_comb begin
    rd_ctl      = '0;
    rd_ctl.did  = did_q;
    rd_ctl.pid  = pid_q;
    rd_ctl.perm = perm_q;
    rd_ctl.go   = busy_i;
    rdata_o     = '0;
    if (cap_i) begin
      case (addr_i)
        IDX_IOVA: rdata_o = iova_q;
        IDX_CTL:  rdata_o = DATA_W'(rd_ctl);
        IDX_RSP:  rdata_o = rsp_i;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign iova_o = iova_q;
  assign pid_o  = pid_q;
  assign did_o  = did_q;
  assign perm_o = perm_q;

  a_r9_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(iova_q) && $stable(pid_q) && $stable(did_q) && $stable(perm_q)));

  a_r1_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |-> (rdata_o == '0 && !launch_o));
endmodule

// File: rtl/dbg_xlate_fsm.sv
module dbg_xlate_fsm
  import dbg_xlate_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                launch_i,
  input  logic                ready_i,
  input  logic                rsp_valid_i,
  input  logic                fault_i,
  input  logic                mrif_i,
  input  logic [CAUSE_W-1:0]  cause_i,
  input  logic [PPN_W-1:0]    ppn_i,
  input  logic [ATTR_W-1:0]   attr_i,
  output logic                busy_o,
  output logic                req_valid_o,
  output logic [DATA_W-1:0]   rsp_o,
  output logic                flt_valid_o,
  output logic [CAUSE_W-1:0]  flt_cause_o
);
  xl_state_e    st_q;
  rsp_reg_t     rsp_q, rsp_ok, rsp_bad;
  logic         flt_q;
  logic [CAUSE_W-1:0] cause_q;
  logic         done, is_fault;

  assign done     = (st_q == ST_WAIT) && rsp_valid_i;
  assign is_fault = fault_i || mrif_i;

  always_comb begin
    rsp_ok       = '0;
    rsp_ok.ppn   = ppn_i;
    rsp_ok.attr  = attr_i;
    rsp_bad      = '0;
    rsp_bad.fault = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      rsp_q   <= '0;
      flt_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      flt_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (launch_i) begin
          st_q  <= ST_ISSUE;
          rsp_q <= '0;
        end
        ST_ISSUE: if (ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          st_q <= ST_IDLE;
          if (is_fault) begin
            rsp_q   <= rsp_bad;
            flt_q   <= 1'b1;
            cause_q <= mrif_i ? CAUSE_TTYPE_BLOCKED : cause_i;
          end else begin
            rsp_q <= rsp_ok;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign req_valid_o = (st_q == ST_ISSUE);
  assign rsp_o       = DATA_W'(rsp_q);
  assign flt_valid_o = flt_q;
  assign flt_cause_o = cause_q;

  a_r3_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> (req_valid_o && rsp_o == '0));
  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done) |=> busy_o);
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !ready_i) |=> req_valid_o);
  a_r7_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_o |=> !flt_valid_o);
  a_r7_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_o |-> (rsp_o == 64'h1 && !busy_o));
endmodule

// File: rtl/dbg_xlate_regs.sv
module dbg_xlate_regs
  import dbg_xlate_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dbg_cap_i,
  input  logic                reg_we_i,
  input  logic [IDX_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                eng_req_valid_o,
  input  logic                eng_req_ready_i,
  output logic [DATA_W-1:0]   eng_req_iova_o,
  output logic [PID_W-1:0]    eng_req_pid_o,
  output logic [DID_W-1:0]    eng_req_did_o,
  output logic [PERM_W-1:0]   eng_req_perm_o,
  output logic                eng_req_no_alloc_o,
  output logic                eng_req_untrans_o,
  input  logic                eng_rsp_valid_i,
  input  logic                eng_rsp_fault_i,
  input  logic                eng_rsp_mrif_i,
  input  logic [CAUSE_W-1:0]  eng_rsp_cause_i,
  input  logic [PPN_W-1:0]    eng_rsp_ppn_i,
  input  logic [ATTR_W-1:0]   eng_rsp_attr_i,
  output logic                flt_valid_o,
  output logic [CAUSE_W-1:0]  flt_cause_o,
  output logic [DATA_W-1:0]   flt_iova_o,
  output logic [DID_W-1:0]    flt_did_o
);
  logic              busy, launch;
  logic [DATA_W-1:0] rsp;

  dbg_xlate_csr u_csr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (dbg_cap_i),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .busy_i  (busy),
    .rsp_i   (rsp),
    .launch_o(launch),
    .rdata_o (reg_rdata_o),
    .iova_o  (eng_req_iova_o),
    .pid_o   (eng_req_pid_o),
    .did_o   (eng_req_did_o),
    .perm_o  (eng_req_perm_o)
  );

  dbg_xlate_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .ready_i     (eng_req_ready_i),
    .rsp_valid_i (eng_rsp_valid_i),
    .fault_i     (eng_rsp_fault_i),
    .mrif_i      (eng_rsp_mrif_i),
    .cause_i     (eng_rsp_cause_i),
    .ppn_i       (eng_rsp_ppn_i),
    .attr_i      (eng_rsp_attr_i),
    .busy_o      (busy),
    .req_valid_o (eng_req_valid_o),
    .rsp_o       (rsp),
    .flt_valid_o (flt_valid_o),
    .flt_cause_o (flt_cause_o)
  );

  // debug requests never fill the cache and count as untranslated
  assign eng_req_no_alloc_o = 1'b1;
  assign eng_req_untrans_o  = 1'b1;
  // address and device ID stay frozen until the next accepted write
  assign flt_iova_o = eng_req_iova_o;
  assign flt_did_o  = eng_req_did_o;

  a_r5_one_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_valid_o |-> (busy && !launch));
  a_r10_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_valid_o |-> (eng_req_no_alloc_o && eng_req_untrans_o));
endmodule

// File: tb/dbg_xlate_regs_tb.sv
module dbg_xlate_regs_tb;
  logic        clk = 1'b0, rst_ni = 1'b0, cap = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [63:0] wdata = '0, rdata;
  logic        vld, rdy = 1'b0, noal, untr;
  logic [63:0] riova;
  logic [19:0] rpid;
  logic [23:0] rdid;
  logic [2:0]  rperm;
  logic        rspv = 1'b0, rflt = 1'b0, rmrif = 1'b0;
  logic [11:0] rcause = '0;
  logic [53:0] rppn = '0;
  logic [2:0]  rattr = '0;
  logic        fv;
  logic [11:0] fc;
  logic [63:0] fiova;
  logic [23:0] fdid;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbg_xlate_regs u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .dbg_cap_i(cap), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .eng_req_valid_o(vld), .eng_req_ready_i(rdy), .eng_req_iova_o(riova),
    .eng_req_pid_o(rpid), .eng_req_did_o(rdid), .eng_req_perm_o(rperm),
    .eng_req_no_alloc_o(noal), .eng_req_untrans_o(untr),
    .eng_rsp_valid_i(rspv), .eng_rsp_fault_i(rflt), .eng_rsp_mrif_i(rmrif),
    .eng_rsp_cause_i(rcause), .eng_rsp_ppn_i(rppn), .eng_rsp_attr_i(rattr),
    .flt_valid_o(fv), .flt_cause_o(fc), .flt_iova_o(fiova), .flt_did_o(fdid)
  );

  // behavioural reference: 0 idle, 1 issuing, 2 waiting
  int          m_st;
  logic [63:0] m_iova, m_rsp;
  logic [19:0] m_pid;
  logic [23:0] m_did;
  logic [2:0]  m_perm;
  logic        m_fv;
  logic [11:0] m_fc;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_st <= 0; m_iova <= '0; m_rsp <= '0; m_pid <= '0; m_did <= '0;
      m_perm <= '0; m_fv <= 1'b0; m_fc <= '0;
    end else begin
      m_fv <= 1'b0;
      if (m_st == 0) begin
        if (cap && we && addr == 2'd0) m_iova <= wdata;
        if (cap && we && addr == 2'd1) begin
          m_pid <= wdata[31:12]; m_did <= wdata[63:40]; m_perm <= wdata[3:1];
          if (wdata[0]) begin m_st <= 1; m_rsp <= '0; end
        end
      end else if (m_st == 1) begin
        if (rdy) m_st <= 2;
      end else if (rspv) begin
        m_st <= 0;
        if (rflt || rmrif) begin
          m_rsp <= 64'd1; m_fv <= 1'b1; m_fc <= rmrif ? 12'd260 : rcause;
        end else m_rsp <= {rppn, rattr, 7'd0};
      end
    end
  end

  function automatic logic [63:0] exp_rd(input logic [1:0] a);
    if (!cap) return '0;
    case (a)
      2'd0: return m_iova;
      2'd1: return {m_did, 8'h0, m_pid, 8'h0, m_perm, logic'(m_st != 0)};
      2'd2: return m_rsp;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h at %0t", req, got, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(posedge clk) begin
    #1;
    if (rst_ni && !done) begin
      check("R2 rdata", rdata, exp_rd(addr));
      check("R5 valid", 64'(vld), 64'(m_st == 1));
      if (m_st == 1) begin
        check("R3 req iova", riova, m_iova);
        check("R3 req fields", {rpid, rdid, rperm}, {m_pid, m_did, m_perm});
        check("R10 tags", {noal, untr}, 2'b11);
      end
      check("R7 flt valid", 64'(fv), 64'(m_fv));
      if (m_fv) begin
        check("R8 flt cause", 64'(fc), 64'(m_fc));
        check("R7 flt iova", fiova, m_iova);
        check("R7 flt did", 64'(fdid), 64'(m_did));
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [63:0] e);
    addr = a; #1; check(req, rdata, e);
  endtask

  task automatic accept(input int dly);
    for (int i = 0; i < 200 && !vld; i++) @(negedge clk);
    repeat (dly) @(negedge clk);
    rdy = 1'b1; @(negedge clk); rdy = 1'b0;
  endtask

  task automatic respond(input int dly, input logic f, input logic m,
                         input logic [11:0] c, input logic [53:0] p, input logic [2:0] at);
    repeat (dly) @(negedge clk);
    rspv = 1'b1; rflt = f; rmrif = m; rcause = c; rppn = p; rattr = at;
    @(negedge clk);
    rspv = 1'b0; rflt = 1'b0; rmrif = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: hidden when capability off
    rd_chk("R1 reset rd", 2'd1, 64'd0);
    wr(2'd0, 64'hDEAD_BEEF_0000_1000);
    wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    repeat (2) @(negedge clk);
    rd_chk("R1 no valid", 2'd1, 64'd0);
    check("R1 no request", 64'(vld), 64'd0);
    cap = 1'b1;
    @(negedge clk);
    rd_chk("R1 write ignored", 2'd0, 64'd0);
    rd_chk("R1 ctl ignored", 2'd1, 64'd0);
    // R2: legal-bit masking and read-only response
    wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFE);
    rd_chk("R2 ctl mask", 2'd1, 64'hFFFF_FF00_FFFF_F00E);
    wr(2'd2, 64'h1234);
    rd_chk("R2 rsp read-only", 2'd2, 64'd0);
    rd_chk("R2 idx3 zero", 2'd3, 64'd0);
    // R3/R6: clean translation, no delays
    wr(2'd0, 64'h0000_7FFF_1234_5000);
    wr(2'd1, {24'hABCDEF, 8'h0, 20'h00042, 8'h0, 3'b011, 1'b1});
    check("R3 valid next cycle", 64'(vld), 64'd1);
    rd_chk("R3 rsp cleared", 2'd2, 64'd0);
    accept(0);
    respond(0, 1'b0, 1'b0, 12'd0, 54'h2_0000_1234_5678, 3'b101);
    rd_chk("R6 rsp ok", 2'd2, {54'h2_0000_1234_5678, 3'b101, 7'd0});
    rd_chk("R6 go clear", 2'd1, {24'hABCDEF, 8'h0, 20'h00042, 8'h0, 3'b011, 1'b0});
    // R4/R9: writes during busy are dropped
    wr(2'd1, {24'h000111, 8'h0, 20'h00007, 8'h0, 3'b100, 1'b1});
    rd_chk("R3 new rsp cleared", 2'd2, 64'd0);
    wr(2'd0, 64'h1111_2222_3333_4444);
    wr(2'd1, 64'd0);
    rd_chk("R9 iova kept", 2'd0, 64'h1111_2222_3333_4444 ^ 64'h1111_2222_3333_4444 ^ 64'h0000_7FFF_1234_5000);
    rd_chk("R4 go sticky", 2'd1, {24'h000111, 8'h0, 20'h00007, 8'h0, 3'b100, 1'b1});
    accept(3);
    check("R5 single accept", 64'(vld), 64'd0);
    respond(5, 1'b0, 1'b0, 12'd0, 54'h1, 3'b000);
    rd_chk("R6 rsp 2", 2'd2, {54'h1, 3'b000, 7'd0});
    // R7: plain fault
    wr(2'd0, 64'h0000_0000_0BAD_0000);
    wr(2'd1, {24'h00C0DE, 8'h0, 20'h00001, 8'h0, 3'b001, 1'b1});
    accept(1);
    respond(2, 1'b1, 1'b0, 12'd13, 54'h3FF, 3'b111);
    check("R7 flt pulse", 64'(fv), 64'd1);
    check("R7 flt cause", 64'(fc), 64'd13);
    rd_chk("R7 rsp fault", 2'd2, 64'd1);
    @(negedge clk);
    check("R7 pulse one cycle", 64'(fv), 64'd0);
    // R8: MSI in remapped-interrupt-file mode
    wr(2'd1, {24'h00C0DF, 8'h0, 20'h00002, 8'h0, 3'b010, 1'b1});
    accept(0);
    respond(1, 1'b0, 1'b1, 12'd7, 54'h55, 3'b010);
    check("R8 cause 260", 64'(fc), 64'd260);
    rd_chk("R8 rsp fault", 2'd2, 64'd1);
    // R1: hidden again after capability drops
    cap = 1'b0;
    @(negedge clk);
    rd_chk("R1 hidden rsp", 2'd2, 64'd0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule